// File: doc/BRIEF.md
# Multi-Window Nested Scan Controller

This block drives a group of scan windows across a two-dimensional data space. Each window has its own start location, its own inner step vector and its own inner step count. A single outer step vector and outer step count are shared by the whole group.

When the controller starts, every window is placed at its start point. The inner compound pattern then runs once: all windows step together, each by its own vector. After that, the outer pattern moves every window's base point by one outer step, and the inner pattern runs again from the new base. This repeats until the outer count is used up. The last inner pass starts from the outer pattern's end point.

Operators are fired by window movement, not by instructions. Each operator has an activation flag. Whenever the group moves, every active operator receives a one-cycle execute strobe. The strobe is aligned with the new coordinates.

Window k is driven by slice k of every per-window bus, so a window's position in the list selects the physical window it moves. The operator datapaths and the data memory live outside this block.

Top module: `scan_group_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `exec_strobe` are 0 and every window coordinate is 0.
- R2: A `start` sampled while idle sets `busy` and places window k at slice k of `win_start_x`/`win_start_y` in the cycle after that edge. Step vectors, counts and the outer vector are captured at the same edge.
- R3: During an inner pass with count N, every window advances by its own inner step on each of N consecutive cycles. Inner counts are equal across the group, so all windows finish their pass in the same cycle. Two windows may use the same step specification.
- R4: When an inner pass ends and outer steps remain, all windows move in one cycle to their previous base plus the outer step, and the inner pass restarts from there.
- R5: With outer count M, the inner pass runs M+1 times. The scan makes (M+1)·N + M moves in total, and the final pass starts from start + M·outer step.
- R6: On each move, bit j of `exec_strobe` is high for exactly that one cycle if operator j was active at start. The strobe is high in the same cycle the new coordinates appear. Inactive operators never pulse.
- R7: Changes to `op_active` while `busy` is high have no effect on the running scan; they take effect at the next start.
- R8: `done` is a one-cycle pulse in the cycle after the last move. In that cycle `busy` is 0 and `exec_strobe` is 0. The coordinates then hold until the next start.
- R9: `start` asserted while `busy` is high is ignored: the scan and the coordinates continue unaffected.
- R10: Coordinates are unsigned COORD_W-bit values that wrap modulo 2^COORD_W. Step vectors are two's complement COORD_W-bit values.
- R11: With N = 0 only the outer relocations are moves. With N = 0 and M = 0, `done` arrives in the second cycle after start and no strobe is issued.
- R12: A `start` sampled in the `done` cycle begins a new scan at once, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| win_start_x | input | NUM_WIN*COORD_W | Start x per window |
| win_start_y | input | NUM_WIN*COORD_W | Start y per window |
| inner_step_x | input | NUM_WIN*COORD_W | Inner step x per window, two's complement |
| inner_step_y | input | NUM_WIN*COORD_W | Inner step y per window, two's complement |
| inner_count | input | NUM_WIN*CNT_W | Inner steps per pass per window (equal in group) |
| outer_step_x | input | COORD_W | Shared outer step x, two's complement |
| outer_step_y | input | COORD_W | Shared outer step y, two's complement |
| outer_count | input | CNT_W | Number of outer steps |
| op_active | input | NUM_OPS | Activation flag per compound operator |
| win_x | output | NUM_WIN*COORD_W | Current x per window |
| win_y | output | NUM_WIN*COORD_W | Current y per window |
| exec_strobe | output | NUM_OPS | Execute pulse per active operator on each move |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the end of an inner pass and an outer relocation. The relocation both moves the windows and fires the strobes in one cycle, so the expected queue for that cycle carries the new base and the strobe. A wrapping scan makes this visible, because its relocation crosses the coordinate boundary.

The second pair is a finishing scan and a new start. The driver raises `start` in the very cycle `done` is high. The monitor then expects the new start points one cycle after `done`, with no idle gap.

Flag changes and a stray `start` are injected mid-scan. The expected sequence, computed from the original settings, must still match.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } scan_state_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_RELOC = 2'd3
  } win_cmd_e;
endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               inner_all_zero,
  input  logic [CNT_W-1:0]   outer_count,
  input  logic [COORD_W-1:0] outer_step_x,
  input  logic [COORD_W-1:0] outer_step_y,
  output win_cmd_e           cmd,
  output logic [COORD_W-1:0] outer_x_q,
  output logic [COORD_W-1:0] outer_y_q,
  output logic               busy,
  output logic               done
);
  scan_state_e        state_q, state_d;
  logic [CNT_W-1:0]   outer_left_q, outer_left_d;
  logic [COORD_W-1:0] outer_x_d, outer_y_d;
  logic               done_d, done_q;

  always_comb begin
    state_d      = state_q;
    outer_left_d = outer_left_q;
    outer_x_d    = outer_x_q;
    outer_y_d    = outer_y_q;
    done_d       = 1'b0;
    cmd          = CMD_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cmd          = CMD_LOAD;
          state_d      = ST_RUN;
          outer_left_d = outer_count;
          outer_x_d    = outer_step_x;
          outer_y_d    = outer_step_y;
        end
      end
      ST_RUN: begin
        if (!inner_all_zero) begin
          cmd = CMD_STEP;
        end else if (outer_left_q != '0) begin
          cmd          = CMD_RELOC;
          outer_left_d = outer_left_q - 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      outer_left_q <= '0;
      outer_x_q    <= '0;
      outer_y_q    <= '0;
      done_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      outer_left_q <= outer_left_d;
      outer_x_q    <= outer_x_d;
      outer_y_q    <= outer_y_d;
      done_q       <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
endmodule

// File: rtl/scan_window_unit.sv
module scan_window_unit
  import scan_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  win_cmd_e           cmd,
  input  logic [COORD_W-1:0] start_x,
  input  logic [COORD_W-1:0] start_y,
  input  logic [COORD_W-1:0] step_x,
  input  logic [COORD_W-1:0] step_y,
  input  logic [CNT_W-1:0]   count,
  input  logic [COORD_W-1:0] outer_x,
  input  logic [COORD_W-1:0] outer_y,
  output logic [COORD_W-1:0] pos_x,
  output logic [COORD_W-1:0] pos_y,
  output logic               inner_zero
);
  logic [COORD_W-1:0] pos_x_q, pos_y_q, pos_x_d, pos_y_d;
  logic [COORD_W-1:0] base_x_q, base_y_q, base_x_d, base_y_d;
  logic [COORD_W-1:0] stp_x_q, stp_y_q;
  logic [CNT_W-1:0]   cnt_q, left_q, left_d;
  logic               cfg_en;
  logic [COORD_W-1:0] nb_x, nb_y;

  assign cfg_en = (cmd == CMD_LOAD);
  assign nb_x   = base_x_q + outer_x;
  assign nb_y   = base_y_q + outer_y;

  always_comb begin
    pos_x_d  = pos_x_q;
    pos_y_d  = pos_y_q;
    base_x_d = base_x_q;
    base_y_d = base_y_q;
    left_d   = left_q;
    unique case (cmd)
      CMD_LOAD: begin
        pos_x_d  = start_x;
        pos_y_d  = start_y;
        base_x_d = start_x;
        base_y_d = start_y;
        left_d   = count;
      end
      CMD_STEP: begin
        if (left_q != '0) begin
          pos_x_d = pos_x_q + stp_x_q;
          pos_y_d = pos_y_q + stp_y_q;
          left_d  = left_q - 1'b1;
        end
      end
      CMD_RELOC: begin
        base_x_d = nb_x;
        base_y_d = nb_y;
        pos_x_d  = nb_x;
        pos_y_d  = nb_y;
        left_d   = cnt_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_x_q  <= '0;
      pos_y_q  <= '0;
      base_x_q <= '0;
      base_y_q <= '0;
      left_q   <= '0;
    end else begin
      pos_x_q  <= pos_x_d;
      pos_y_q  <= pos_y_d;
      base_x_q <= base_x_d;
      base_y_q <= base_y_d;
      left_q   <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stp_x_q <= '0;
      stp_y_q <= '0;
      cnt_q   <= '0;
    end else if (cfg_en) begin
      stp_x_q <= step_x;
      stp_y_q <= step_y;
      cnt_q   <= count;
    end
  end

  assign pos_x      = pos_x_q;
  assign pos_y      = pos_y_q;
  assign inner_zero = (left_q == '0);
endmodule

// File: rtl/scan_op_trigger.sv
module scan_op_trigger
  import scan_pkg::*;
#(
  parameter int NUM_OPS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  win_cmd_e           cmd,
  input  logic [NUM_OPS-1:0] op_active,
  output logic [NUM_OPS-1:0] flags,
  output logic [NUM_OPS-1:0] exec
);
  logic [NUM_OPS-1:0] flags_q, exec_q, exec_d;
  logic               move, load_en;

  assign load_en = (cmd == CMD_LOAD);
  assign move    = (cmd == CMD_STEP) || (cmd == CMD_RELOC);
  assign exec_d  = move ? flags_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (load_en) flags_q <= op_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exec_q <= '0;
    else exec_q <= exec_d;
  end

  assign flags = flags_q;
  assign exec  = exec_q;
endmodule

// File: rtl/scan_group_ctrl.sv
module scan_group_ctrl
  import scan_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int COORD_W = 8,
  parameter int CNT_W   = 4,
  parameter int NUM_OPS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_WIN*COORD_W-1:0] win_start_x,
  input  logic [NUM_WIN*COORD_W-1:0] win_start_y,
  input  logic [NUM_WIN*COORD_W-1:0] inner_step_x,
  input  logic [NUM_WIN*COORD_W-1:0] inner_step_y,
  input  logic [NUM_WIN*CNT_W-1:0]   inner_count,
  input  logic [COORD_W-1:0]         outer_step_x,
  input  logic [COORD_W-1:0]         outer_step_y,
  input  logic [CNT_W-1:0]           outer_count,
  input  logic [NUM_OPS-1:0]         op_active,
  output logic [NUM_WIN*COORD_W-1:0] win_x,
  output logic [NUM_WIN*COORD_W-1:0] win_y,
  output logic [NUM_OPS-1:0]         exec_strobe,
  output logic                       busy,
  output logic                       done
);
  win_cmd_e           cmd;
  logic [NUM_WIN-1:0] inner_zero;
  logic               inner_all_zero;
  logic [COORD_W-1:0] outer_x_q, outer_y_q;
  logic [NUM_OPS-1:0] flags_q;

  assign inner_all_zero = &inner_zero;

  scan_seq_fsm #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .inner_all_zero(inner_all_zero), .outer_count(outer_count),
    .outer_step_x(outer_step_x), .outer_step_y(outer_step_y),
    .cmd(cmd), .outer_x_q(outer_x_q), .outer_y_q(outer_y_q),
    .busy(busy), .done(done)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    scan_window_unit #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .cmd(cmd),
      .start_x(win_start_x[w*COORD_W +: COORD_W]),
      .start_y(win_start_y[w*COORD_W +: COORD_W]),
      .step_x(inner_step_x[w*COORD_W +: COORD_W]),
      .step_y(inner_step_y[w*COORD_W +: COORD_W]),
      .count(inner_count[w*CNT_W +: CNT_W]),
      .outer_x(outer_x_q), .outer_y(outer_y_q),
      .pos_x(win_x[w*COORD_W +: COORD_W]),
      .pos_y(win_y[w*COORD_W +: COORD_W]),
      .inner_zero(inner_zero[w])
    );
  end

  scan_op_trigger #(.NUM_OPS(NUM_OPS)) u_trig (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .op_active(op_active),
    .flags(flags_q), .exec(exec_strobe)
  );
endmodule

// File: rtl/scan_group_chk.sv
module scan_group_chk #(
  parameter int NUM_WIN = 3,
  parameter int COORD_W = 8,
  parameter int NUM_OPS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [NUM_OPS-1:0]         exec_strobe,
  input logic [NUM_OPS-1:0]         flags_q,
  input logic [NUM_WIN-1:0]         inner_zero,
  input logic [NUM_WIN*COORD_W-1:0] win_start_x,
  input logic [NUM_WIN*COORD_W-1:0] win_start_y,
  input logic [NUM_WIN*COORD_W-1:0] win_x,
  input logic [NUM_WIN*COORD_W-1:0] win_y
);
  // R2
  start_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && win_x == $past(win_start_x) && win_y == $past(win_start_y)));

  // R3
  lockstep_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (inner_zero == '0 || inner_zero == '1));

  // R6
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_strobe != '0) |-> (busy && (exec_strobe & ~flags_q) == '0));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && exec_strobe == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(win_x) && $stable(win_y)));
endmodule

bind scan_group_ctrl scan_group_chk #(.NUM_WIN(NUM_WIN), .COORD_W(COORD_W), .NUM_OPS(NUM_OPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .exec_strobe(exec_strobe), .flags_q(flags_q), .inner_zero(inner_zero),
  .win_start_x(win_start_x), .win_start_y(win_start_y),
  .win_x(win_x), .win_y(win_y)
);

// File: tb/tb_scan_group_ctrl.sv
`timescale 1ns/1ps
module tb_scan_group_ctrl;
  localparam int NW = 3, CW = 8, CN = 4, NO = 4;

  typedef struct packed {
    logic [NW*CW-1:0] x;
    logic [NW*CW-1:0] y;
    logic [NO-1:0]    ex;
    logic             bz;
    logic             dn;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NW*CW-1:0] sx_b, sy_b, stx_b, sty_b, win_x, win_y;
  logic [NW*CN-1:0] cnt_b;
  logic [CW-1:0] ox_b, oy_b;
  logic [CN-1:0] m_b;
  logic [NO-1:0] flags_b, exec_strobe;
  logic busy, done;

  int sx[NW], sy[NW], stx[NW], sty[NW];
  int ox, oy, n_in, m_out;
  item_t q[$];
  string qt[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      sx_b[w*CW +: CW]  = CW'(sx[w]);
      sy_b[w*CW +: CW]  = CW'(sy[w]);
      stx_b[w*CW +: CW] = CW'(stx[w]);
      sty_b[w*CW +: CW] = CW'(sty[w]);
      cnt_b[w*CN +: CN] = CN'(n_in);
    end
    ox_b = CW'(ox);
    oy_b = CW'(oy);
    m_b  = CN'(m_out);
  end

  scan_group_ctrl #(.NUM_WIN(NW), .COORD_W(CW), .CNT_W(CN), .NUM_OPS(NO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .win_start_x(sx_b), .win_start_y(sy_b),
    .inner_step_x(stx_b), .inner_step_y(sty_b), .inner_count(cnt_b),
    .outer_step_x(ox_b), .outer_step_y(oy_b), .outer_count(m_b),
    .op_active(flags_b), .win_x(win_x), .win_y(win_y),
    .exec_strobe(exec_strobe), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per clock edge after it was queued
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      string t;
      e = q.pop_front();
      t = qt.pop_front();
      check(t, {win_x, win_y, exec_strobe, busy, done}, {e.x, e.y, e.ex, e.bz, e.dn});
    end
  end

  function automatic item_t mk(input int p, input int i, input logic [NO-1:0] ex,
                               input logic bz, input logic dn);
    item_t it;
    for (int w = 0; w < NW; w++) begin
      it.x[w*CW +: CW] = CW'(sx[w] + p*ox + i*stx[w]);
      it.y[w*CW +: CW] = CW'(sy[w] + p*oy + i*sty[w]);
    end
    it.ex = ex; it.bz = bz; it.dn = dn;
    return it;
  endfunction

  // driver: queue the full expected scan, then pulse start
  task automatic run_job(input string tag, input logic [NO-1:0] fl,
                         input bit chg, input logic [NO-1:0] fl2, input bit poke);
    while (q.size() != 0) @(negedge clk);
    flags_b = fl;
    q.push_back(mk(0, 0, '0, 1'b1, 1'b0)); qt.push_back({tag, " R2 start placement"});
    for (int p = 0; p <= m_out; p++) begin
      if (p > 0) begin
        q.push_back(mk(p, 0, fl, 1'b1, 1'b0)); qt.push_back({tag, " R4 outer relocation"});
      end
      for (int i = 1; i <= n_in; i++) begin
        q.push_back(mk(p, i, fl, 1'b1, 1'b0)); qt.push_back({tag, " R3 inner step"});
      end
    end
    q.push_back(mk(m_out, n_in, '0, 1'b0, 1'b1)); qt.push_back({tag, " R8 done"});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (chg) flags_b = fl2;  // R7
    if (poke) begin          // R9
      int keep;
      keep = sx[0];
      sx[0] = 77;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sx[0] = keep;
    end
  endtask

  initial begin
    sx = '{0, 2, 2}; sy = '{0, 0, 8};
    stx = '{1, 0, 0}; sty = '{0, 1, 1};
    ox = 1; oy = 1; n_in = 3; m_out = 2;
    flags_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 256'(busy), 256'(0));
    check("R1 done", 256'(done), 256'(0));
    check("R1 exec", 256'(exec_strobe), 256'(0));
    check("R1 coords", 256'({win_x, win_y}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R5 R6: three windows, shared spec on two, three inner passes
    run_job("R5 R6 nested", 4'b0101, 0, '0, 0);
    // R11: no inner steps, no outer steps
    n_in = 0; m_out = 0;
    run_job("R11 empty", 4'b1111, 0, '0, 0);
    // R11: relocations only
    n_in = 0; m_out = 2; ox = 3; oy = -1;
    run_job("R11 outer only", 4'b0011, 0, '0, 0);
    // R10 wrap, with R7 flag change and R9 stray start mid-scan
    sx = '{250, 1, 128}; sy = '{3, 0, 255};
    stx = '{3, -1, 2}; sty = '{-2, -1, 2};
    n_in = 4; m_out = 1; ox = -5; oy = 0;
    run_job("R10 R7 R9 wrap", 4'b0010, 1, 4'b1000, 1);
    // R12 back-to-back (start raised in the done cycle), new flags R7
    n_in = 2; m_out = 1; ox = 0; oy = 4;
    run_job("R12 R7 back-to-back", 4'b1000, 0, '0, 0);
    run_job("R6 all passive", 4'b0000, 0, '0, 0);
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8 idle hold
    check("R8 idle busy", 256'(busy), 256'(0));
    check("R8 idle exec", 256'(exec_strobe), 256'(0));
    check("R8 idle hold", 256'({win_x, win_y}), 256'({mk(1, 2, '0, 0, 0).x, mk(1, 2, '0, 0, 0).y}));
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule